// File: doc/BRIEF.md
# Carriage-Return Automatic Bit-Rate Detector

After reset this block watches an idle-high asynchronous serial receive line and infers the host's bit rate from the first character the host sends, which is a carriage return (0x0D). The frame is one start bit, eight data bits sent least-significant first, no parity and one stop bit. For 0x0D the start bit is followed by a high data bit, so the first low run on the line lasts exactly one bit time. The block counts that low run in system clock cycles, snaps the count to one of seven standard rates, and presents the rate index, the matching clock divisor and a sticky locked flag. A single-cycle sign-on pulse tells the transmitter it may send its greeting at the new rate.

The line first passes through a two-flop synchroniser and a glitch filter. A measurement that falls outside the supported range is discarded, and the detector waits for the next falling edge. Once locked, the result holds until the next reset.

Top module: `cr_autobaud`

## Requirements
- R1: During and directly after reset, `rate_locked`, `signon`, `rate_idx` and `baud_div` are all zero.
- R2: Rate index k (0 to 6) stands for 300·2^k baud, so 0 is 300 and 6 is 19200. With k locked, `baud_div` equals floor(CLK_HZ / (300·2^k)). With the default 1 MHz clock the values are 3333, 1666, 833, 416, 208, 104 and 52.
- R3: The measured width is the number of clock cycles of the first low run on the filtered line. A carriage return sent at any supported rate locks to that rate's index.
- R4: Let p_k be the divisor of index k. Threshold t_k = floor((p_k + p_{k+1}) / 2) for k = 0 to 5. The locked index is the number of thresholds strictly greater than the width, so a width equal to a threshold selects the slower rate.
- R5: `rate_locked` and `signon` first read high on the clock edge GL+3 edges after the line returns high, counting as edge 1 the first edge that samples it high. GL = floor(p_6 / 4), which is 13 by default.
- R6: A width below p_6 − floor(p_6/4) (39 by default) or above p_0 + floor(p_0/4) (4166 by default) causes no lock. The detector then measures the next low run.
- R7: A line level held for fewer than GL cycles is ignored by the filter. A high blip of that length inside a start bit therefore does not split the measurement.
- R8: After lock, further activity on `rx_in` changes neither `rate_idx` nor `baud_div` and raises no further `signon`, until reset.
- R9: `signon` is high for exactly one cycle per lock, in the cycle where `rate_locked` rises.
- R10: A reset clears a previous lock, and the detector then locks afresh to the next carriage return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high, asynchronous |
| rate_locked | output | 1 | Sticky flag: a rate has been detected |
| rate_idx | output | IDX_W | Detected rate index, 0 = 300 baud up to 6 = 19200 baud |
| baud_div | output | DIV_W | Clock cycles per bit at the detected rate |
| signon | output | 1 | One-cycle pulse when the lock is taken |

## Verification
The assertions assume that `rx_in` idles high out of reset. Under that assumption the filtered line starts high and every lock is preceded by a completed low run. The bench drives `rx_in` only on falling clock edges and holds every level for a whole number of cycles. Levels are held long enough to pass the filter, except where a short blip is deliberately injected. Low runs are chosen to land exactly on the threshold and range boundaries, to cover the tie rule and both rejection cases.

// File: rtl/crab_pkg.sv
package crab_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_HIGH,
    ST_ARMED,
    ST_MEASURE,
    ST_LOCKED
  } crab_state_e;

  // clock cycles per bit for rate index k
  function automatic int unsigned rate_period(input int unsigned clk_hz,
                                              input int unsigned base_baud,
                                              input int unsigned k);
    return clk_hz / (base_baud << k);
  endfunction

  // decision point between index k and index k+1
  function automatic int unsigned rate_threshold(input int unsigned clk_hz,
                                                 input int unsigned base_baud,
                                                 input int unsigned k);
    return (rate_period(clk_hz, base_baud, k) +
            rate_period(clk_hz, base_baud, k + 1)) / 2;
  endfunction

  function automatic int unsigned glitch_cycles(input int unsigned clk_hz,
                                                input int unsigned base_baud,
                                                input int unsigned n_rates);
    int unsigned g;
    g = rate_period(clk_hz, base_baud, n_rates - 1) / 4;
    return (g == 0) ? 1 : g;
  endfunction

  function automatic int unsigned min_width(input int unsigned clk_hz,
                                            input int unsigned base_baud,
                                            input int unsigned n_rates);
    int unsigned p;
    p = rate_period(clk_hz, base_baud, n_rates - 1);
    return p - p / 4;
  endfunction

  function automatic int unsigned max_width(input int unsigned clk_hz,
                                            input int unsigned base_baud);
    int unsigned p;
    p = rate_period(clk_hz, base_baud, 0);
    return p + p / 4;
  endfunction

endpackage

// File: rtl/crab_sync.sv
module crab_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta_q;
  logic sync_q;

  // idle level of the line is high, so both stages reset high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/crab_deglitch.sv
module crab_deglitch #(
  parameter int unsigned GL = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned RUN_W = $clog2(GL + 1);

  logic             level_q;
  logic [RUN_W-1:0] run_q;

  // level follows din only after GL consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (din == level_q) begin
      run_q <= '0;
    end else if (run_q == RUN_W'(GL - 1)) begin
      level_q <= din;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign dout = level_q;
endmodule

// File: rtl/crab_measure.sv
module crab_measure
  import crab_pkg::*;
#(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned WMAX  = 4166
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             take,
  output logic [CNT_W-1:0] width,
  output logic             done
);
  crab_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  // a low run has just ended; width holds its length
  assign done  = (state_q == ST_MEASURE) && line;
  assign width = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_HIGH;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_WAIT_HIGH: if (line) state_q <= ST_ARMED;
        ST_ARMED: begin
          if (!line) begin
            state_q <= ST_MEASURE;
            cnt_q   <= CNT_W'(1);
          end
        end
        ST_MEASURE: begin
          if (line) begin
            state_q <= take ? ST_LOCKED : ST_ARMED;
          end else if (cnt_q >= CNT_W'(WMAX)) begin
            state_q <= ST_WAIT_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOCKED: state_q <= ST_LOCKED;
        default:   state_q <= ST_WAIT_HIGH;
      endcase
    end
  end
endmodule

// File: rtl/crab_classify.sv
module crab_classify
  import crab_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 1000000,
  parameter int unsigned BASE_BAUD = 300,
  parameter int unsigned NUM_RATES = 7,
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned WMIN      = 39,
  parameter int unsigned WMAX      = 4166
) (
  input  logic [CNT_W-1:0] width,
  output logic [IDX_W-1:0] idx,
  output logic             in_range
);
  logic [NUM_RATES-2:0] slower_than;

  // one comparator per boundary between neighbouring rates
  for (genvar k = 0; k < NUM_RATES - 1; k++) begin : g_thr
    localparam int unsigned TH = rate_threshold(CLK_HZ, BASE_BAUD, k);
    assign slower_than[k] = (width < CNT_W'(TH));
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_RATES - 1; k++) begin
      idx = idx + IDX_W'(slower_than[k]);
    end
  end

  assign in_range = (width >= CNT_W'(WMIN)) && (width <= CNT_W'(WMAX));
endmodule

// File: rtl/cr_autobaud.sv
module cr_autobaud
  import crab_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 1000000,
  parameter int unsigned BASE_BAUD = 300,
  parameter int unsigned NUM_RATES = 7,
  parameter int unsigned IDX_W     = $clog2(NUM_RATES),
  parameter int unsigned DIV_W     = $clog2(CLK_HZ / BASE_BAUD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  output logic             rate_locked,
  output logic [IDX_W-1:0] rate_idx,
  output logic [DIV_W-1:0] baud_div,
  output logic             signon
);
  localparam int unsigned GL    = glitch_cycles(CLK_HZ, BASE_BAUD, NUM_RATES);
  localparam int unsigned WMIN  = min_width(CLK_HZ, BASE_BAUD, NUM_RATES);
  localparam int unsigned WMAX  = max_width(CLK_HZ, BASE_BAUD);
  localparam int unsigned CNT_W = $clog2(WMAX + 1) + 1;

  logic             rx_sync;
  logic             rx_clean;
  logic [CNT_W-1:0] meas_width;
  logic             meas_done;
  logic [IDX_W-1:0] cls_idx;
  logic             width_ok;
  logic [DIV_W-1:0] div_sel;
  logic [DIV_W-1:0] div_tab [NUM_RATES];

  crab_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_in),
    .dout (rx_sync)
  );

  crab_deglitch #(.GL(GL)) u_dg (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_sync),
    .dout (rx_clean)
  );

  crab_measure #(.CNT_W(CNT_W), .WMAX(WMAX)) u_meas (
    .clk  (clk),
    .rst_n(rst_n),
    .line (rx_clean),
    .take (width_ok),
    .width(meas_width),
    .done (meas_done)
  );

  crab_classify #(
    .CLK_HZ   (CLK_HZ),
    .BASE_BAUD(BASE_BAUD),
    .NUM_RATES(NUM_RATES),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W),
    .WMIN     (WMIN),
    .WMAX     (WMAX)
  ) u_cls (
    .width   (meas_width),
    .idx     (cls_idx),
    .in_range(width_ok)
  );

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_div
    assign div_tab[k] = DIV_W'(rate_period(CLK_HZ, BASE_BAUD, k));
  end

  always_comb begin
    div_sel = '0;
    for (int k = 0; k < NUM_RATES; k++) begin
      if (cls_idx == IDX_W'(k)) div_sel = div_tab[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_locked <= 1'b0;
      rate_idx    <= '0;
      baud_div    <= '0;
      signon      <= 1'b0;
    end else begin
      signon <= 1'b0;
      if (meas_done && width_ok && !rate_locked) begin
        rate_locked <= 1'b1;
        rate_idx    <= cls_idx;
        baud_div    <= div_sel;
        signon      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crab_chk.sv
module crab_chk #(
  parameter int unsigned NUM_RATES = 7,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned DIV_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_sync,
  input logic             rx_clean,
  input logic             rate_locked,
  input logic [IDX_W-1:0] rate_idx,
  input logic [DIV_W-1:0] baud_div,
  input logic             signon
);
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_locked |=> rate_locked && $stable(rate_idx) && $stable(baud_div));

  // R9
  signon_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    signon |=> !signon);

  // R9
  signon_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    signon |-> rate_locked && !$past(rate_locked));

  // R7
  filter_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clean != $past(rx_clean)) |-> ($past(rx_sync) != $past(rx_clean)));

  // R6
  lock_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_locked) |-> $past(rx_clean));

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_locked |-> (rate_idx <= IDX_W'(NUM_RATES - 1)));
endmodule

bind cr_autobaud crab_chk #(
  .NUM_RATES(NUM_RATES),
  .IDX_W    (IDX_W),
  .DIV_W    (DIV_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_sync    (rx_sync),
  .rx_clean   (rx_clean),
  .rate_locked(rate_locked),
  .rate_idx   (rate_idx),
  .baud_div   (baud_div),
  .signon     (signon)
);

// File: tb/sim_cr_autobaud.sv
module sim_cr_autobaud;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1000000;
  localparam int NR         = 7;
  localparam int IW         = 3;
  localparam int DW         = 12;
  localparam int WDOG       = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic          rate_locked;
  logic [IW-1:0] rate_idx;
  logic [DW-1:0] baud_div;
  logic          signon;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cr_autobaud #(.CLK_HZ(CLK_HZ)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_in      (rx),
    .rate_locked(rate_locked),
    .rate_idx   (rate_idx),
    .baud_div   (baud_div),
    .signon     (signon)
  );

  function automatic int per(int k);
    return CLK_HZ / (300 * (1 << k));
  endfunction

  localparam int GL   = (CLK_HZ / (300 * 64)) / 4;
  localparam int WLO  = (CLK_HZ / (300 * 64)) - GL;
  localparam int WHI  = (CLK_HZ / 300) + (CLK_HZ / 300) / 4;

  function automatic int pick(int w);
    int n = 0;
    for (int k = 0; k < NR - 1; k++) if ((per(k) + per(k + 1)) / 2 > w) n++;
    return n;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: history of samples, run lengths, integer state
  bit hist[$];
  bit m_clean;
  int m_state;
  int m_w;
  bit m_locked;
  int m_idx;
  int m_div;
  bit m_pulse;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < GL + 2; i++) hist.push_back(1'b1);
      m_clean = 1; m_state = 0; m_w = 0;
      m_locked = 0; m_idx = 0; m_div = 0; m_pulse = 0;
    end else begin
      bit differ;
      int n;
      hist.push_back(rx);
      n = hist.size();
      differ = 1;
      for (int j = 0; j < GL; j++) if (hist[n - 3 - j] == m_clean) differ = 0;
      m_pulse = 0;
      case (m_state)
        0: if (m_clean) m_state = 1;
        1: if (!m_clean) begin m_state = 2; m_w = 1; end
        2: begin
          if (m_clean) begin
            if (m_w >= WLO && m_w <= WHI) begin
              m_state = 3;
              m_locked = 1; m_idx = pick(m_w); m_div = per(m_idx); m_pulse = 1;
            end else m_state = 1;
          end else if (m_w >= WHI) m_state = 0;
          else m_w++;
        end
        default: ;
      endcase
      if (differ) m_clean = hist[n - 3];
      while (hist.size() > GL + 2) void'(hist.pop_front());
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    check(rate_locked == m_locked, "R5 model locked", rate_locked, m_locked);
    check(signon == m_pulse, "R9 model signon", signon, m_pulse);
    check(rate_idx == IW'(m_idx), "R4 model idx", rate_idx, m_idx);
    check(baud_div == DW'(m_div), "R2 model div", baud_div, m_div);
  end

  always @(negedge clk) if (signon) pulses++;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG) begin
      check(0, "watchdog", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(bit lvl, int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    rx = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    pulses = 0;
  endtask

  task automatic send_char(int p, logic [7:0] b);
    drive(0, p);
    for (int i = 0; i < 8; i++) drive(b[i], p);
    drive(1, p);
  endtask

  task automatic expect_lock(string tag, int k);
    check(rate_locked == 1, tag, rate_locked, 1);
    check(rate_idx == IW'(k), tag, rate_idx, k);
    check(baud_div == DW'(per(k)), tag, baud_div, per(k));
    check(pulses == 1, tag, pulses, 1);
  endtask

  initial begin
    int lat;
    rst_n = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(rate_locked == 0 && signon == 0, "R1 flags", rate_locked, 0);
    check(rate_idx == 0 && baud_div == 0, "R1 values", baud_div, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 every rate from a carriage return
    for (int k = 0; k < NR; k++) begin
      do_reset();
      drive(1, 50);
      send_char(per(k), 8'h0D);
      drive(1, 20);
      expect_lock("R3 carriage return", k);
    end

    // R5 latency from the rising edge of the start bit
    do_reset();
    drive(1, 30);
    drive(0, 104);
    rx = 1;
    lat = 0;
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      if (rate_locked && lat == 0) lat = c;
    end
    check(lat == GL + 3, "R5 latency", lat, GL + 3);

    // R4 threshold between 1200 and 2400: tie goes slower
    do_reset();
    drive(1, 20); drive(0, 623); drive(1, GL + 10);
    expect_lock("R4 below threshold", 3);
    do_reset();
    drive(1, 20); drive(0, 624); drive(1, GL + 10);
    expect_lock("R4 on threshold", 2);
    do_reset();
    drive(1, 20); drive(0, 540); drive(1, GL + 10);
    expect_lock("R4 off-nominal", 3);

    // R6 too short, then the shortest accepted width
    do_reset();
    drive(1, 20); drive(0, WLO - 1); drive(1, GL + 30);
    check(rate_locked == 0, "R6 short rejected", rate_locked, 0);
    drive(0, WLO); drive(1, GL + 10);
    expect_lock("R6 shortest accepted", 6);

    // R6 too long, then the longest accepted width
    do_reset();
    drive(1, 20); drive(0, WHI + 1); drive(1, GL + 30);
    check(rate_locked == 0, "R6 long rejected", rate_locked, 0);
    drive(0, WHI); drive(1, GL + 10);
    expect_lock("R6 longest accepted", 0);

    // R7 short blips are filtered
    do_reset();
    drive(1, 20); drive(0, GL - 1); drive(1, 60);
    check(rate_locked == 0, "R7 low blip", rate_locked, 0);
    drive(0, 400); drive(1, GL - 1); drive(0, 833 - 400 - (GL - 1)); drive(1, GL + 10);
    expect_lock("R7 high blip inside start bit", 2);

    // R8 later activity ignored
    do_reset();
    drive(1, 20);
    send_char(per(5), 8'h0D);
    drive(1, 20);
    expect_lock("R8 first lock", 5);
    drive(0, per(0)); drive(1, 100);
    send_char(per(6), 8'h55);
    drive(1, 50);
    expect_lock("R8 after further traffic", 5);

    // R10 reset clears and re-arms
    rst_n = 0;
    @(negedge clk);
    check(rate_locked == 0, "R10 cleared", rate_locked, 0);
    do_reset();
    drive(1, 20);
    send_char(per(4), 8'h0D);
    drive(1, 20);
    expect_lock("R10 relock", 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule